// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address sequence of a four-beat burst. On an enabled clock edge with the advance input low, it captures a full external address. That address is the first beat of a new burst, and the beat index returns to zero. On each enabled edge with the advance input high, the beat index moves forward by one. The two low address bits are then recomputed from the captured starting bits and the beat index. The upper address bits keep the value captured at load.

A static order input selects how the low bits move. Low gives an incrementing order that wraps modulo four. High gives an interleaved order, where the low bits are the starting bits XOR the beat index. A disabled clock edge freezes all state. A burst that runs past four beats keeps cycling inside the same aligned group of four addresses. Decoding the memory cycle type and accessing the memory are left to the logic around this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `cur_addr` is 0 and `beat` is 0.
- R2: After an edge with `clk_en`=1 and `advance`=0, `cur_addr` equals the `ext_addr` value that edge sampled, and `beat` is 0.
- R3: After an edge with `clk_en`=1 and `advance`=1, `beat` equals its previous value plus one, modulo 4.
- R4: With `order_sel`=0 (linear), `cur_addr[1:0]` equals (starting bits + `beat`) modulo 4. For example, a start of 2'b10 gives 10, 11, 00, 01.
- R5: With `order_sel`=1 (interleaved), `cur_addr[1:0]` equals the starting bits XOR `beat`. For example, a start of 2'b01 gives 01, 00, 11, 10.
- R6: An edge with `advance`=1 leaves `cur_addr[AW-1:2]` unchanged.
- R7: An edge with `clk_en`=0 leaves `cur_addr` and `beat` unchanged, whatever `advance` and `ext_addr` are.
- R8: A burst that continues past four beats returns to its starting address on the fifth beat and repeats the same four addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Edge enable; 0 freezes all state |
| advance | input | 1 | 0 loads `ext_addr`, 1 steps the burst |
| order_sel | input | 1 | Static order select: 0 linear, 1 interleaved |
| ext_addr | input | AW | External starting address |
| cur_addr | output | AW | Current full burst address |
| beat | output | 2 | Beat index within the burst |

## Verification
On every cycle, the assertions check the edge-to-edge relations. A load takes in the sampled address and clears the beat. A step raises the beat by one and leaves the upper bits alone. A disabled edge changes nothing. Each step also moves the low bits by the amount the selected order calls for. The bench's sweeps must show the absolute sequences: all four starting offsets in both orders, compared against a formula. They must also show wrapping beyond four beats, loads in the middle of a burst, and the reset value.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int OFS_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  function automatic logic [OFS_W-1:0] beat_next(input logic [OFS_W-1:0] b);
    return OFS_W'(b + 1'b1);
  endfunction

  function automatic logic [OFS_W-1:0] linear_ofs(input logic [OFS_W-1:0] s,
                                                  input logic [OFS_W-1:0] b);
    return OFS_W'(s + b);
  endfunction

  function automatic logic [OFS_W-1:0] interleave_ofs(input logic [OFS_W-1:0] s,
                                                      input logic [OFS_W-1:0] b);
    return s ^ b;
  endfunction
endpackage

// File: rtl/bag_seq_ctl.sv
module bag_seq_ctl (
  input  logic clk_en,
  input  logic advance,
  output logic load_ev,
  output logic step_ev
);
  always_comb begin
    load_ev = clk_en & ~advance;
    step_ev = clk_en &  advance;
  end
endmodule

// File: rtl/bag_base_reg.sv
module bag_base_reg #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ev,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (load_ev) base_q <= ext_addr;
  end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
  import bag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_ev,
  input  logic             step_ev,
  output logic [OFS_W-1:0] beat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       beat_q <= '0;
    else if (load_ev) beat_q <= '0;
    else if (step_ev) beat_q <= beat_next(beat_q);
  end
endmodule

// File: rtl/bag_offset_map.sv
module bag_offset_map
  import bag_pkg::*;
(
  input  order_e           order,
  input  logic [OFS_W-1:0] start_ofs,
  input  logic [OFS_W-1:0] beat_q,
  output logic [OFS_W-1:0] ofs
);
  always_comb begin
    unique case (order)
      ORD_LINEAR:     ofs = linear_ofs(start_ofs, beat_q);
      ORD_INTERLEAVE: ofs = interleave_ofs(start_ofs, beat_q);
      default:        ofs = start_ofs;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          advance,
  input  logic          order_sel,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cur_addr,
  output logic [1:0]    beat
);
  localparam int HI_W = AW - OFS_W;

  logic             load_ev;
  logic             step_ev;
  logic [AW-1:0]    base_q;
  logic [OFS_W-1:0] beat_q;
  logic [OFS_W-1:0] ofs;
  order_e           order;

  assign order = order_e'(order_sel);

  bag_seq_ctl u_ctl (
    .clk_en (clk_en),
    .advance(advance),
    .load_ev(load_ev),
    .step_ev(step_ev)
  );

  bag_base_reg #(.AW(AW)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_ev (load_ev),
    .ext_addr(ext_addr),
    .base_q  (base_q)
  );

  bag_beat_ctr u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_ev(load_ev),
    .step_ev(step_ev),
    .beat_q (beat_q)
  );

  bag_offset_map u_map (
    .order    (order),
    .start_ofs(base_q[OFS_W-1:0]),
    .beat_q   (beat_q),
    .ofs      (ofs)
  );

  assign cur_addr = {base_q[AW-1:AW-HI_W], ofs};
  assign beat     = beat_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          advance,
  input logic          order_sel,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] cur_addr,
  input logic [1:0]    beat
);
  // R1
  reset_value_chk: assert property (@(posedge clk)
    !rst_n |=> (cur_addr == '0) && (beat == 2'd0));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !advance) |=> (cur_addr == $past(ext_addr)) && (beat == 2'd0));

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && advance) |=> beat == 2'($past(beat) + 2'd1));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && advance && !order_sel) |=>
      cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1));

  // R5
  interleave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && advance && order_sel) |=>
      cur_addr[1:0] == ($past(cur_addr[1:0]) ^ $past(beat) ^ 2'($past(beat) + 2'd1)));

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && advance) |=> $stable(cur_addr[AW-1:2]));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(cur_addr) && $stable(beat));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en   (clk_en),
  .advance  (advance),
  .order_sel(order_sel),
  .ext_addr (ext_addr),
  .cur_addr (cur_addr),
  .beat     (beat)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b0;
  logic          advance = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;
  logic [1:0]    beat;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.AW(AW)) i_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .advance(advance),
    .order_sel(order_sel), .ext_addr(ext_addr), .cur_addr(cur_addr), .beat(beat)
  );

  function automatic logic [AW-1:0] expect_addr();
    int s;
    int lo;
    s = int'(m_base[1:0]);
    if (order_sel) begin
      lo = 0;
      for (int k = 0; k < 2; k++)
        if (((s >> k) & 1) != ((m_beat >> k) & 1)) lo += (1 << k);
    end else begin
      lo = (s + m_beat) % 4;
    end
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(input string req);
    logic [AW-1:0] ea;
    ea = expect_addr();
    vectors++;
    if (cur_addr !== ea || beat !== 2'(m_beat)) begin
      miscompares++;
      $display("FAIL %s: cur_addr=%h beat=%0d expected cur_addr=%h beat=%0d",
               req, cur_addr, beat, ea, m_beat);
    end
  endtask

  task automatic edge_apply(input logic en, input logic adv, input logic [AW-1:0] a,
                            input string req);
    @(negedge clk);
    clk_en = en; advance = adv; ext_addr = a;
    @(posedge clk);
    if (en && !adv) begin m_base = a; m_beat = 0; end
    else if (en && adv) m_beat = (m_beat + 1) % 4;
    #1;
    check(req);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; clk_en = 1'b1; advance = 1'b0;
    ext_addr = 20'hABCDE; order_sel = mode;
    @(posedge clk); @(posedge clk);
    m_base = '0; m_beat = 0;
    #1; check("R1 reset");
    @(negedge clk); rst_n = 1'b1; clk_en = 1'b0;
    @(posedge clk); #1; check("R1 after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] hi;
    for (int mode = 0; mode < 2; mode++) begin
      do_reset(1'(mode));
      for (int up = 0; up < 3; up++) begin
        hi = (up == 0) ? 20'h00000 : (up == 1) ? 20'hFFFFC : 20'h5A5A4;
        for (int s = 0; s < 4; s++) begin
          edge_apply(1'b1, 1'b0, hi | AW'(s), "R2 load");
          for (int b = 0; b < 9; b++) begin
            // R3 R4 R5 R6 step; beats past 4 cover R8
            edge_apply(1'b1, 1'b1, ~hi, mode ? "R5 R3 R6 R8 step" : "R4 R3 R6 R8 step");
            if (b == 2) begin
              // R7 disabled edges with both advance values and a new address
              edge_apply(1'b0, 1'b1, 20'h12345, "R7 stall adv");
              edge_apply(1'b0, 1'b0, 20'h6789A, "R7 stall load");
            end
          end
          // R2 load in mid burst restarts
          edge_apply(1'b1, 1'b1, '0, "R3 step");
          edge_apply(1'b1, 1'b0, hi | AW'(3 - s), "R2 mid-burst load");
          edge_apply(1'b1, 1'b1, '0, mode ? "R5 step" : "R4 step");
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule